// File: doc/BRIEF.md
# Complementary PWM Phase Generator with Dead-Time Insertion

This block drives one high-side/low-side pair of a motor bridge leg. A carrier counter fixes the PWM period, a duty comparator decides when the phase is on, and a retriggerable one-shot blanks both outputs for a programmable number of clocks around every switching edge. This prevents the two transistors of the leg from conducting at the same time. The carrier runs either as a down-counting sawtooth or as an up/down triangle. A divider raises a one-cycle interrupt after a programmable number of carrier bottoms, so software can refresh the duty value at a lower rate.

The carrier, duty, dead-time and divider values are register contents presented on input ports. The duty value is taken over only at the carrier bottom, so a write in the middle of a period never cuts a pulse short. Clearing the run input stops the block, reloads the counters and parks both outputs in their inactive level. Output polarity is selectable.

Top module: `pwm_phase_dt`

## Requirements
- R1: After reset, and whenever run_i is 0, both u_o and ub_o are at the inactive level and irq_o is 0.
- R2: In sawtooth mode (saw_mode_i=1) the carrier counts carrier_ld_i down to 0 and then reloads, so the period is carrier_ld_i+1 clocks. The phase is on while the count is below the duty value, which gives duty_ld_i on-clocks per period.
- R3: In triangle mode (saw_mode_i=0, carrier_ld_i of at least 2) the carrier counts down to 0 and back up to carrier_ld_i, so the period is 2*carrier_ld_i clocks. The on-time is 2*duty_ld_i-1 clocks for a duty value from 1 to carrier_ld_i.
- R4: A new duty value takes effect only at a clock in which the carrier count is 0, or while the block is stopped.
- R5: Each switching edge of the phase inserts exactly dead_ld_i clocks in which both outputs are inactive. With dead_ld_i=0 the outputs switch directly.
- R6: An edge that arrives while the dead-time count is still running restarts the count from dead_ld_i. A pulse no longer than the dead time therefore never turns the high side on.
- R7: With pol_hi_i=1 an active output is 1. With pol_hi_i=0 an active output is 0.
- R8: irq_o pulses for one clock once every irq_div_i+1 carrier bottoms.
- R9: A duty value of 0 keeps the high side off for the whole period. A duty value above the carrier peak keeps it on for the whole period. Neither case inserts dead time.
- R10: u_o and ub_o are never active in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start/run enable |
| saw_mode_i | input | 1 | 1 selects sawtooth, 0 selects triangle carrier |
| pol_hi_i | input | 1 | 1 makes the outputs active-high |
| carrier_ld_i | input | 16 | Carrier reload (peak) value |
| duty_ld_i | input | 16 | Duty compare value |
| dead_ld_i | input | 8 | Dead-time length in clocks |
| irq_div_i | input | 4 | Carrier bottoms per interrupt, minus one |
| u_o | output | 1 | High-side drive |
| ub_o | output | 1 | Low-side drive |
| irq_o | output | 1 | Carrier interrupt pulse |

## Verification
The dead-time one-shot can be reloaded by a new switching edge in the same clock in which it would otherwise keep counting down. This is provoked with a duty of 2 against a dead time of 4. It is judged by counting whole periods in which the high side must never turn on and in which the low side is blanked for exactly the on-time plus the dead time. The carrier bottom can also coincide with a duty write and with an interrupt. A duty change made while the block runs is judged by the on-time of the whole periods that follow. The interrupt count over a window of a whole number of divider periods must match exactly.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  localparam int CNT_W = 16;
  localparam int DT_W  = 8;
  localparam int DIV_W = 4;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import pwm_dt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         saw_i,
  input  logic [W-1:0] ld_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;
  dir_e         dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_DOWN;
    end else if (!run_i) begin
      cnt_q <= ld_i;
      dir_q <= DIR_DOWN;
    end else if (saw_i) begin
      cnt_q <= (cnt_q == '0) ? ld_i : cnt_q - 1'b1;
      dir_q <= DIR_DOWN;
    end else if (dir_q == DIR_DOWN) begin
      if (cnt_q == '0) begin
        cnt_q <= {{(W-1){1'b0}}, 1'b1};
        dir_q <= DIR_UP;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (cnt_q >= ld_i - 1'b1) begin
      cnt_q <= ld_i;
      dir_q <= DIR_DOWN;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = run_i && (cnt_q == '0);

  p_saw_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && saw_i && cnt_q == '0) |=> (cnt_q == $past(ld_i)));
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
  parameter int W = pwm_dt_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         uf_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] duty_ld_i,
  output logic         on_o
);
  logic [W-1:0] duty_q;

  // take the new compare value only at the carrier bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             duty_q <= '0;
    else if (!run_i || uf_i) duty_q <= duty_ld_i;
  end

  assign on_o = cnt_i < duty_q;

  p_duty_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_q) |-> $past(!run_i || cnt_i == '0));
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int DW = pwm_dt_pkg::DT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          on_i,
  input  logic [DW-1:0] dead_ld_i,
  output logic          hi_act_o,
  output logic          lo_act_o
);
  logic          on_q;
  logic [DW-1:0] dt_q;
  logic          edge_w;

  assign edge_w = on_i ^ on_q;

  // retriggerable one-shot: every edge restarts the blanking count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q <= 1'b0;
      dt_q <= '0;
    end else if (!run_i) begin
      on_q <= 1'b0;
      dt_q <= '0;
    end else begin
      on_q <= on_i;
      if (edge_w)            dt_q <= dead_ld_i;
      else if (dt_q != '0)   dt_q <= dt_q - 1'b1;
    end
  end

  assign hi_act_o = run_i &&  on_q && (dt_q == '0);
  assign lo_act_o = run_i && !on_q && (dt_q == '0);

  p_dead_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && on_q != $past(on_q) && $past(dead_ld_i) != '0)
      |-> (!hi_act_o && !lo_act_o));
endmodule

// File: rtl/pwm_irq_div.sv
module pwm_irq_div #(
  parameter int DVW = pwm_dt_pkg::DIV_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           uf_i,
  input  logic [DVW-1:0] div_i,
  output logic           irq_o
);
  logic [DVW-1:0] n_q;
  logic           irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      irq_q <= 1'b0;
    end else if (!run_i) begin
      n_q   <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= uf_i && (n_q >= div_i);
      if (uf_i) n_q <= (n_q >= div_i) ? '0 : n_q + 1'b1;
    end
  end

  assign irq_o = irq_q;

  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(uf_i));
endmodule

// File: rtl/pwm_phase_dt.sv
module pwm_phase_dt
  import pwm_dt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             saw_mode_i,
  input  logic             pol_hi_i,
  input  logic [CNT_W-1:0] carrier_ld_i,
  input  logic [CNT_W-1:0] duty_ld_i,
  input  logic [DT_W-1:0]  dead_ld_i,
  input  logic [DIV_W-1:0] irq_div_i,
  output logic             u_o,
  output logic             ub_o,
  output logic             irq_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_w;
  logic             uf_w, on_w, hi_w, lo_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_i;
  end

  pwm_carrier #(.W(CNT_W)) u_carrier (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .saw_i(saw_mode_i),
    .ld_i(carrier_ld_i), .cnt_o(cnt_w), .uf_o(uf_w)
  );

  pwm_duty #(.W(CNT_W)) u_duty (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .uf_i(uf_w),
    .cnt_i(cnt_w), .duty_ld_i(duty_ld_i), .on_o(on_w)
  );

  pwm_deadtime #(.DW(DT_W)) u_dead (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .on_i(on_w),
    .dead_ld_i(dead_ld_i), .hi_act_o(hi_w), .lo_act_o(lo_w)
  );

  pwm_irq_div #(.DVW(DIV_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .uf_i(uf_w),
    .div_i(irq_div_i), .irq_o(irq_o)
  );

  assign u_o  = pol_hi_i ? hi_w : ~hi_w;
  assign ub_o = pol_hi_i ? lo_w : ~lo_w;

  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((u_o == pol_hi_i) && (ub_o == pol_hi_i)));
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (u_o != pol_hi_i && ub_o != pol_hi_i && !irq_o));
endmodule

// File: tb/pwm_phase_dt_tb_top.sv
module pwm_phase_dt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, saw = 1'b1, pol = 1'b1;
  logic [15:0] car = 16'd9, duty = 16'd4;
  logic [7:0]  dead = 8'd1;
  logic [3:0]  div = 4'd0;
  logic u, ub, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_phase_dt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .saw_mode_i(saw), .pol_hi_i(pol),
    .carrier_ld_i(car), .duty_ld_i(duty), .dead_ld_i(dead), .irq_div_i(div),
    .u_o(u), .ub_o(ub), .irq_o(irq)
  );

  // per entry: mode, polarity, carrier, duty, dead, divider, hi/lo on-clocks per period
  localparam int NV = 7;
  localparam int V_SAW[NV]  = '{1, 1, 0, 0, 1, 1, 0};
  localparam int V_POL[NV]  = '{1, 0, 1, 0, 1, 1, 1};
  localparam int V_CAR[NV]  = '{9, 15, 8, 6, 9, 7, 5};
  localparam int V_DUT[NV]  = '{4, 8, 3, 6, 2, 0, 9};
  localparam int V_DT[NV]   = '{1, 2, 1, 0, 4, 3, 2};
  localparam int V_DIV[NV]  = '{0, 2, 1, 0, 0, 3, 0};
  localparam int V_HI[NV]   = '{3, 6, 4, 11, 0, 0, 10};
  localparam int V_LO[NV]   = '{5, 6, 10, 1, 4, 8, 0};
  localparam int NPER = 4;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int w, output int hi, output int lo, output int both, output int nirq);
    hi = 0; lo = 0; both = 0; nirq = 0;
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      if (u == pol) hi++;
      if (ub == pol) lo++;
      if (u != pol && ub != pol) both++;
      if (irq) nirq++;
    end
  endtask

  initial begin
    int hi, lo, both, nirq, per, w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(u == 1'b0 && ub == 1'b0 && irq == 1'b0, "R1 in reset", {u, ub, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(u == 1'b0 && ub == 1'b0 && irq == 1'b0, "R1 after reset, stopped", {u, ub, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      run = 1'b0;
      saw = V_SAW[i][0]; pol = V_POL[i][0];
      car = 16'(V_CAR[i]); duty = 16'(V_DUT[i]);
      dead = 8'(V_DT[i]); div = 4'(V_DIV[i]);
      repeat (3) @(negedge clk);
      // R7 idle level follows polarity
      chk(u == ~pol && ub == ~pol, "R7 idle level", {u, ub}, {~pol, ~pol});
      per = V_SAW[i] != 0 ? V_CAR[i] + 1 : 2 * V_CAR[i];
      w = NPER * per * (V_DIV[i] + 1);
      run = 1'b1;
      repeat (3 * per * (V_DIV[i] + 1) + 5) @(negedge clk);
      measure(w, hi, lo, both, nirq);
      // R2/R3/R9 high-side on-time, R6 for entry 4
      chk(hi == V_HI[i] * NPER * (V_DIV[i] + 1), "R2 R3 R6 R9 high-side clocks", hi,
          V_HI[i] * NPER * (V_DIV[i] + 1));
      chk(lo == V_LO[i] * NPER * (V_DIV[i] + 1), "R2 R3 R6 R9 low-side clocks", lo,
          V_LO[i] * NPER * (V_DIV[i] + 1));
      // R5 blanking and R10 no overlap: blank + hi + lo fills the window
      chk(both == w - hi - lo && hi + lo <= w, "R5 R10 blank clocks", both, w - hi - lo);
      chk(nirq == NPER, "R8 interrupt count", nirq, NPER);
    end

    // R4 duty write while running: whole periods afterwards use the new value
    run = 1'b0; saw = 1'b1; pol = 1'b1; car = 16'd9; duty = 16'd4; dead = 8'd1; div = 4'd0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    repeat (17) @(negedge clk);
    duty = 16'd7;
    repeat (25) @(negedge clk);
    measure(40, hi, lo, both, nirq);
    chk(hi == 24, "R4 high-side after duty write", hi, 24);
    chk(lo == 8, "R4 low-side after duty write", lo, 8);

    // R1 stop parks outputs
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk(u == 1'b0 && ub == 1'b0 && irq == 1'b0, "R1 stop parks outputs", {u, ub, irq}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule